// File: doc/BRIEF.md
# Unary-Tagged Register Dependency Scoreboard

This block decides when instructions may enter function units and when those units may read operands and write results. Each architectural register carries a one-wire-per-unit vector naming the unit that will next write it. Every tag match is therefore a plain AND per bit, with no comparator bank. Source and destination registers arrive as bit masks, one wire per register. Several registers can be looked up or marked on the same wires in one cycle, which is what multi-issue needs.

An issue request names a target unit (one-hot), a destination register (one-hot) and a set of source registers (any number of bits). The request stalls in the same cycle if the destination already has an outstanding writer, if the unit is busy, or if the unit or destination fields are not one-hot. Conflicts where a later writer overwrites a value an earlier unit still has to read do not stall. Instead the writer's write grant is held back until those readers have read. Each unit then runs two request/grant handshakes: one to read operands and one to write its result. A handshake completes in any cycle where the request and the grant are both high.

Top module: `sb_unary_scoreboard`

## Requirements
- R1: After reset, `fu_busy`, `reg_pend`, `rd_go`, `wr_go` and `iss_stall` are all zero.
- R2: An issue with `iss_valid` high and `iss_stall` low is accepted at the clock edge. From the next cycle the target unit's `fu_busy` bit and the destination's `reg_pend` bit are high. Bit f of `iss_fu` selects unit f, and bit r of `iss_dst` or `iss_src` selects register r.
- R3: If the destination register already has a pending writer, `iss_stall` is high in the same cycle. The request then changes no busy or pending state.
- R4: An issue aimed at a unit whose `fu_busy` bit is high is refused with `iss_stall` in the same cycle.
- R5: `rd_go[f]` stays low while any source register of unit f is still to be written by a unit that was busy when f issued. It rises from the cycle after the last such write completes.
- R6: `iss_src` may carry several register bits at once. The read grant then waits for the producers of all of them, and `reg_pend` can show several registers pending together.
- R7: Issuing a writer to a register that an earlier, unread unit names as a source does not stall. That writer's `wr_go` stays low until every such reader has completed its read.
- R8: A completed write (`wr_req` and `wr_go` both high) clears that unit's `fu_busy` bit and its destination's `reg_pend` bit from the next cycle.
- R9: A grant is never given without its request. `wr_go[f]` is never high before unit f has completed its read, and `rd_go[f]` is never high after it.
- R10: An issue whose `iss_fu` or `iss_dst` is not exactly one-hot is refused with `iss_stall` and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request present |
| iss_fu | input | NUM_FU | Target unit, one-hot |
| iss_dst | input | NUM_REG | Destination register, one-hot |
| iss_src | input | NUM_REG | Source registers, any number of bits |
| iss_stall | output | 1 | Issue refused this cycle |
| rd_req | input | NUM_FU | Per-unit operand read request |
| rd_go | output | NUM_FU | Per-unit operand read grant |
| wr_req | input | NUM_FU | Per-unit result write request |
| wr_go | output | NUM_FU | Per-unit result write grant |
| fu_busy | output | NUM_FU | Unit holds an issued instruction |
| reg_pend | output | NUM_REG | Register has an outstanding writer |

## Verification
A lost producer bit shows at the ports within one cycle. `reg_pend` drops early, a later consumer gets `rd_go` before its producer's write, and a second writer to the same register is accepted instead of stalled. A bit left set too long shows as `iss_stall` or a withheld grant that never clears. The directed bench catches it at the very next issue or grant attempt. A wrong entry in the read-before-write matrix shows as a `wr_go` that appears before the earlier reader's `rd_go` handshake, or one that never appears after it. Both are sampled in the cycle the grant is requested.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int unsigned SB_DEF_FU  = 8;
  localparam int unsigned SB_DEF_REG = 16;

  typedef enum logic [1:0] {
    SC_NONE      = 2'd0,
    SC_MALFORMED = 2'd1,
    SC_UNIT_BUSY = 2'd2,
    SC_WAW       = 2'd3
  } stall_cause_e;
endpackage

// File: rtl/sb_producer_table.sv
module sb_producer_table #(
  parameter int unsigned NFU  = 8,
  parameter int unsigned NREG = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [NFU-1:0]  set_fu,
  input  logic [NREG-1:0] dst_mask,
  input  logic [NREG-1:0] src_mask,
  input  logic [NFU-1:0]  clr_fu,
  output logic [NFU-1:0]  src_prod,
  output logic            dst_busy,
  output logic [NREG-1:0] reg_pend
);
  logic [NREG-1:0][NFU-1:0] prod_q;

  // OR of the producer vectors of every selected register: one AND per bit
  function automatic logic [NFU-1:0] gather(input logic [NREG-1:0][NFU-1:0] tbl,
                                            input logic [NREG-1:0] sel);
    logic [NFU-1:0] acc;
    acc = '0;
    for (int r = 0; r < NREG; r++) acc |= tbl[r] & {NFU{sel[r]}};
    return acc;
  endfunction

  assign src_prod = gather(prod_q, src_mask);
  assign dst_busy = |gather(prod_q, dst_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
    end else begin
      for (int r = 0; r < NREG; r++)
        prod_q[r] <= (prod_q[r] & ~clr_fu) | ((set_en && dst_mask[r]) ? set_fu : '0);
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_pend
    assign reg_pend[r] = |prod_q[r];
    assert_one_writer_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(prod_q[r]));
  end

  assert_set_on_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !dst_busy);
endmodule

// File: rtl/sb_fu_status.sv
module sb_fu_status #(
  parameter int unsigned NFU  = 8,
  parameter int unsigned NREG = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic [NFU-1:0]  acc_fu,
  input  logic [NREG-1:0] acc_dst,
  input  logic [NREG-1:0] acc_src,
  input  logic [NFU-1:0]  rd_done,
  input  logic [NFU-1:0]  wr_done,
  output logic [NFU-1:0]  busy,
  output logic [NFU-1:0]  read_done,
  output logic [NFU-1:0]  war_readers
);
  logic [NFU-1:0]           busy_q, rdone_q;
  logic [NFU-1:0][NREG-1:0] src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= '0;
      rdone_q <= '0;
      src_q   <= '0;
    end else begin
      for (int f = 0; f < NFU; f++) begin
        if (accept && acc_fu[f]) begin
          busy_q[f]  <= 1'b1;
          rdone_q[f] <= 1'b0;
          src_q[f]   <= acc_src;
        end else begin
          if (rd_done[f]) begin
            rdone_q[f] <= 1'b1;
            src_q[f]   <= '0;
          end
          if (wr_done[f]) busy_q[f] <= 1'b0;
        end
      end
    end
  end

  assign busy      = busy_q;
  assign read_done = rdone_q;

  // units still holding an unread source equal to the incoming destination
  for (genvar f = 0; f < NFU; f++) begin : g_war
    assign war_readers[f] = busy_q[f] & ~rdone_q[f] & (|(src_q[f] & acc_dst));

    assert_write_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done[f] |-> rdone_q[f]);
    assert_read_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done[f] |-> (busy_q[f] && !rdone_q[f]));
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done[f] |=> !busy_q[f]);
  end
endmodule

// File: rtl/sb_dep_matrix.sv
module sb_dep_matrix #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_row,
  input  logic [N-1:0] set_cols,
  input  logic [N-1:0] clr_cols,
  output logic [N-1:0] row_free
);
  logic [N-1:0][N-1:0] dep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dep_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (set_row[i]) dep_q[i] <= set_cols & ~clr_cols;
        else            dep_q[i] <= dep_q[i] & ~clr_cols;
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_row
    assign row_free[i] = ~|dep_q[i];
    assert_no_self_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !dep_q[i][i]);
  end
endmodule

// File: rtl/sb_unary_scoreboard.sv
module sb_unary_scoreboard
  import sb_pkg::*;
#(
  parameter int unsigned NUM_FU  = SB_DEF_FU,
  parameter int unsigned NUM_REG = SB_DEF_REG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               iss_valid,
  input  logic [NUM_FU-1:0]  iss_fu,
  input  logic [NUM_REG-1:0] iss_dst,
  input  logic [NUM_REG-1:0] iss_src,
  output logic               iss_stall,
  input  logic [NUM_FU-1:0]  rd_req,
  output logic [NUM_FU-1:0]  rd_go,
  input  logic [NUM_FU-1:0]  wr_req,
  output logic [NUM_FU-1:0]  wr_go,
  output logic [NUM_FU-1:0]  fu_busy,
  output logic [NUM_REG-1:0] reg_pend
);
  logic [NUM_FU-1:0] src_prod, busy, read_done, war_readers, raw_free, war_free;
  logic              dst_busy, accept;
  stall_cause_e      stall_cause;
  logic [NUM_FU-1:0] acc_row;

  always_comb begin
    stall_cause = SC_NONE;
    if (iss_valid) begin
      if (!$onehot(iss_fu) || !$onehot(iss_dst)) stall_cause = SC_MALFORMED;
      else if (|(iss_fu & busy))                 stall_cause = SC_UNIT_BUSY;
      else if (dst_busy)                         stall_cause = SC_WAW;
    end
  end

  assign iss_stall = (stall_cause != SC_NONE);
  assign accept    = iss_valid && !iss_stall;
  assign acc_row   = accept ? iss_fu : '0;

  sb_producer_table #(.NFU(NUM_FU), .NREG(NUM_REG)) u_prod (
    .clk, .rst_n,
    .set_en   (accept),
    .set_fu   (iss_fu),
    .dst_mask (iss_dst),
    .src_mask (iss_src),
    .clr_fu   (wr_go),
    .src_prod (src_prod),
    .dst_busy (dst_busy),
    .reg_pend (reg_pend)
  );

  sb_fu_status #(.NFU(NUM_FU), .NREG(NUM_REG)) u_status (
    .clk, .rst_n,
    .accept      (accept),
    .acc_fu      (iss_fu),
    .acc_dst     (iss_dst),
    .acc_src     (iss_src),
    .rd_done     (rd_go),
    .wr_done     (wr_go),
    .busy        (busy),
    .read_done   (read_done),
    .war_readers (war_readers)
  );

  // read waits on producers (RAW)
  sb_dep_matrix #(.N(NUM_FU)) u_raw (
    .clk, .rst_n,
    .set_row  (acc_row),
    .set_cols (src_prod & ~iss_fu),
    .clr_cols (wr_go),
    .row_free (raw_free)
  );

  // write waits on earlier readers (WAR)
  sb_dep_matrix #(.N(NUM_FU)) u_war (
    .clk, .rst_n,
    .set_row  (acc_row),
    .set_cols (war_readers & ~iss_fu),
    .clr_cols (rd_go),
    .row_free (war_free)
  );

  assign rd_go   = rd_req & busy & ~read_done & raw_free;
  assign wr_go   = wr_req & busy & read_done & war_free;
  assign fu_busy = busy;

  assert_waw_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && (|(iss_dst & reg_pend))) |-> iss_stall);
  assert_busy_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && (|(iss_fu & fu_busy))) |-> iss_stall);
  assert_stall_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
    iss_stall |=> (fu_busy == ($past(fu_busy) & ~$past(wr_go))));
  assert_accept_marks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_stall) |=> (|(fu_busy & $past(iss_fu))));
  assert_grant_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_go & ~rd_req) == '0) && ((wr_go & ~wr_req) == '0));
endmodule

// File: tb/test_sb_unary_scoreboard.sv
module test_sb_unary_scoreboard;
  localparam int NF = 8;
  localparam int NR = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          iss_valid = 1'b0;
  logic [NF-1:0] iss_fu = '0;
  logic [NR-1:0] iss_dst = '0;
  logic [NR-1:0] iss_src = '0;
  logic          iss_stall;
  logic [NF-1:0] rd_req = '0, wr_req = '0;
  logic [NF-1:0] rd_go, wr_go, fu_busy;
  logic [NR-1:0] reg_pend;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sb_unary_scoreboard #(.NUM_FU(NF), .NUM_REG(NR)) i_sb_unary_scoreboard (
    .clk, .rst_n, .iss_valid, .iss_fu, .iss_dst, .iss_src, .iss_stall,
    .rd_req, .rd_go, .wr_req, .wr_go, .fu_busy, .reg_pend
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive an issue, check stall in the same cycle, let the edge pass
  task automatic issue(input string req, input logic [NF-1:0] fu, input logic [NR-1:0] dst,
                       input logic [NR-1:0] src, input bit exp_stall);
    @(negedge clk);
    iss_valid = 1'b1; iss_fu = fu; iss_dst = dst; iss_src = src;
    #1 check(req, "iss_stall", iss_stall, exp_stall);
    @(posedge clk); #1;
    iss_valid = 1'b0; iss_fu = '0; iss_dst = '0; iss_src = '0;
  endtask

  task automatic try_read(input string req, input int f, input bit exp_go);
    @(negedge clk);
    rd_req = NF'(1) << f;
    #1 check(req, $sformatf("rd_go[%0d]", f), rd_go[f], exp_go);
    @(posedge clk); #1 rd_req = '0;
  endtask

  task automatic try_write(input string req, input int f, input bit exp_go);
    @(negedge clk);
    wr_req = NF'(1) << f;
    #1 check(req, $sformatf("wr_go[%0d]", f), wr_go[f], exp_go);
    @(posedge clk); #1 wr_req = '0;
  endtask

  task automatic finish_unit(input string req, input int f);
    try_read(req, f, 1'b1);
    try_write(req, f, 1'b1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "fu_busy", fu_busy, 0);
    check("R1", "reg_pend", reg_pend, 0);
    check("R1", "rd_go", rd_go, 0);
    check("R1", "wr_go", wr_go, 0);
    check("R1", "iss_stall", iss_stall, 0);
  endtask

  task automatic t_raw_chain();
    issue("R2", 8'h01, 16'h0002, 16'h0004, 1'b0);   // FU0: r1 <- r2
    @(negedge clk);
    check("R2", "fu_busy", fu_busy, 8'h01);
    check("R2", "reg_pend", reg_pend, 16'h0002);
    issue("R5", 8'h02, 16'h0008, 16'h0002, 1'b0);   // FU1: r3 <- r1
    try_read("R5", 1, 1'b0);
    try_write("R9", 0, 1'b0);                        // FU0 not yet read
    try_read("R5", 0, 1'b1);
    try_read("R9", 0, 1'b0);                         // no second read
    try_read("R5", 1, 1'b0);                         // producer still pending
    try_write("R8", 0, 1'b1);
    @(negedge clk);
    check("R8", "fu_busy", fu_busy, 8'h02);
    check("R8", "reg_pend", reg_pend, 16'h0008);
    try_read("R5", 1, 1'b1);
    try_write("R8", 1, 1'b1);
    @(negedge clk);
    check("R8", "fu_busy", fu_busy, 0);
    check("R8", "reg_pend", reg_pend, 0);
  endtask

  task automatic t_war();
    issue("R7", 8'h04, 16'h0040, 16'h0020, 1'b0);   // FU2: r6 <- r5
    issue("R7", 8'h08, 16'h0020, 16'h0000, 1'b0);   // FU3: r5, no stall
    try_read("R7", 3, 1'b1);
    try_write("R7", 3, 1'b0);                        // held for FU2's read
    try_read("R7", 2, 1'b1);
    try_write("R7", 3, 1'b1);
    try_write("R8", 2, 1'b1);
    @(negedge clk);
    check("R7", "fu_busy", fu_busy, 0);
  endtask

  task automatic t_waw_and_busy();
    issue("R3", 8'h10, 16'h0080, 16'h0000, 1'b0);   // FU4: r7
    issue("R3", 8'h20, 16'h0080, 16'h0000, 1'b1);   // FU5: r7 -> WAW
    @(negedge clk);
    check("R3", "fu_busy", fu_busy, 8'h10);
    check("R3", "reg_pend", reg_pend, 16'h0080);
    finish_unit("R3", 4);
    issue("R3", 8'h20, 16'h0080, 16'h0000, 1'b0);   // now free
    issue("R4", 8'h20, 16'h0100, 16'h0000, 1'b1);   // FU5 busy
    @(negedge clk);
    check("R4", "reg_pend", reg_pend, 16'h0080);
    finish_unit("R4", 5);
  endtask

  task automatic t_two_sources();
    issue("R6", 8'h01, 16'h0200, 16'h0000, 1'b0);   // FU0: r9
    issue("R6", 8'h02, 16'h0400, 16'h0000, 1'b0);   // FU1: r10
    @(negedge clk);
    check("R6", "reg_pend", reg_pend, 16'h0600);
    issue("R6", 8'h04, 16'h0800, 16'h0600, 1'b0);   // FU2: r11 <- r9, r10
    try_read("R6", 2, 1'b0);
    finish_unit("R6", 0);
    try_read("R6", 2, 1'b0);                         // r10 still pending
    finish_unit("R6", 1);
    try_read("R6", 2, 1'b1);
    try_write("R6", 2, 1'b1);
  endtask

  task automatic t_malformed();
    issue("R10", 8'h03, 16'h1000, 16'h0000, 1'b1);  // two units
    issue("R10", 8'h40, 16'h0000, 16'h0000, 1'b1);  // no destination
    issue("R10", 8'h40, 16'h3000, 16'h0000, 1'b1);  // two destinations
    @(negedge clk);
    check("R10", "fu_busy", fu_busy, 0);
    check("R10", "reg_pend", reg_pend, 0);
  endtask

  initial begin
    #3000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_raw_chain();
    t_war();
    t_waw_and_busy();
    t_two_sources();
    t_malformed();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule